// File: doc/BRIEF.md
# Two-Stage Pixel Clock Divider

This block derives a pixel-rate clock from one of several source clocks. Each source reaches the block as a one-cycle tick strobe that is synchronous to the block clock, with one tick per source period. The selected tick train first passes through an integer divider by N (1 to 32). The result then passes through a power-of-two divider by 2^E (E from 0 to 5). The pixel period is therefore N·2^E source ticks. The block drives a registered pixel clock level and a one-cycle strobe that marks the first tick of each pixel period.

Software sets the block up through two registers. The control register holds the enable, the source code and the exponent. A wider shared register holds N-1 in a five-bit field, and the rest of that register belongs to other logic. The field can be written on its own without touching the neighbouring bits. Both registers read back. A status output flags whether the current source code names a source that exists. New divide settings are taken up only when a pixel period ends, so a pulse is never cut short by reprogramming.

Top module: `pixdiv_top`

## Requirements
- R1: The control register reads back with the source code in bits 1:0, the enable in bit 2 and the exponent in bits 5:3. It holds its value except on a write, and it resets to 0.
- R2: An exponent written above 5 is stored and read back as 5.
- R3: A full write replaces the whole shared register. A field write changes only bits 7:3, which hold N-1, and leaves every other bit unchanged. When both writes occur in the same cycle, bits 7:3 come from the field write.
- R4: While the block is enabled with a valid source, each pixel period lasts N·2^E selected ticks. pix_stb is high for one cycle after the tick that starts each period, and at no other time.
- R5: Counting the ticks of a period from 0, pix_clk is high from tick 0 up to, but not including, tick ceil(N·2^E/2), and low for the rest of the period. For odd N with E=0, the high phase is therefore one tick longer than the low phase.
- R6: When the enable bit is clear, pix_clk and pix_stb are low from the next cycle on. The first selected tick after the block is enabled starts a fresh period with pix_clk high.
- R7: Source code 0 selects src_tick[0] and code 1 selects src_tick[1]. Codes 2 and 3 are invalid: src_ok is low and the output stays idle, as if the block were disabled.
- R8: Changes to N or E made during a period take effect only at the next period boundary.
- R9: Ticks on a source that is not selected have no effect on pix_clk or pix_stb.
- R10: With N=1 and E=0, pix_clk stays high and pix_stb pulses on every selected tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | NSRC | One tick strobe for each source clock |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control register write data |
| shr_we | input | 1 | Shared register full write strobe |
| shr_wdata | input | SHR_W | Shared register write data |
| nfld_we | input | 1 | Write strobe for the N-1 field only |
| nfld_wdata | input | 5 | New N-1 value |
| ctl_rdata | output | 6 | Control register readback |
| shr_rdata | output | SHR_W | Shared register readback |
| src_ok | output | 1 | The selected source code is valid |
| pix_clk | output | 1 | Divided pixel clock level |
| pix_stb | output | 1 | One-cycle pulse at the start of each pixel period |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- the exponent cap;
- the idle output when the block is disabled or the source is invalid;
- preservation of the neighbouring shared-register bits during a field write;
- that each strobe follows a selected tick and coincides with a high level;
- that the output holds when no selected tick arrives.

Period length, duty split, deferred reload at the boundary and the degenerate divide-by-one case depend on counts over many ticks. Only the bench scenarios can show these, by comparing against a tick-position model under random tick trains and reprogramming.

// File: rtl/pixdiv_pkg.sv
package pixdiv_pkg;

    // Field widths of the configuration registers
    localparam int NDIV_W = 5;                      // N-1 field width
    localparam int EXP_W  = 3;                      // exponent field width
    localparam int SEL_W  = 2;                      // source code width
    localparam int CTL_W  = EXP_W + 1 + SEL_W;      // control register width

    // Control register layout: exponent[5:3], enable[2], source[1:0]
    typedef struct packed {
        logic [EXP_W-1:0] exp;
        logic             en;
        logic [SEL_W-1:0] sel;
    } ctl_t;

endpackage

// File: rtl/pixdiv_regs.sv
module pixdiv_regs
    import pixdiv_pkg::*;
#(
    parameter int SHR_W = 32,
    parameter int NLSB  = 3,
    parameter int EMAX  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              shr_we,
    input  logic [SHR_W-1:0]  shr_wdata,
    input  logic              nfld_we,
    input  logic [NDIV_W-1:0] nfld_wdata,
    output ctl_t              ctl_q,
    output logic [SHR_W-1:0]  shr_q,
    output logic [NDIV_W-1:0] ndiv_m1
);

    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EMAX);

    typedef struct packed {
        ctl_t             ctl;
        logic [SHR_W-1:0] shr;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl = ctl_t'(ctl_wdata);
            if (st_d.ctl.exp > EXP_CAP) begin
                st_d.ctl.exp = EXP_CAP;
            end
        end
        if (shr_we) begin
            st_d.shr = shr_wdata;
        end
        // Field write: only the N-1 bits change, the neighbours are kept
        if (nfld_we) begin
            st_d.shr[NLSB +: NDIV_W] = nfld_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q   = st_q.ctl;
    assign shr_q   = st_q.shr;
    assign ndiv_m1 = st_q.shr[NLSB +: NDIV_W];

endmodule

// File: rtl/pixdiv_ndiv.sv
// First stage: counts source ticks modulo N and reports the phase level.
module pixdiv_ndiv #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] lim,      // N-1
    output logic         wrap,     // last tick of this stage's cycle
    output logic         hi_d      // level of the next position (used when E=0)
);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W:0]   half;            // ceil(N/2)

    always_comb begin
        half  = ({1'b0, lim} + (W+1)'(2)) >> 1;
        wrap  = 1'b0;
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (adv) begin
            if (cnt_q == lim) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
        hi_d = ({1'b0, cnt_d} < half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pixdiv_pow2.sv
// Second stage: counts first-stage cycles modulo 2^E.
module pixdiv_pow2 #(
    parameter int W  = 5,
    parameter int EW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    input  logic [EW-1:0] exp,
    output logic          wrap,
    output logic          hi_d     // next position in lower half of the period
);

    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] mask;            // 2^E - 1
    logic [W-1:0] top;             // bit E-1 alone, zero when E=0

    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < int'(exp));
        end
        top   = mask ^ (mask >> 1);
        wrap  = 1'b0;
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (adv) begin
            if (cnt_q == mask) begin
                cnt_d = '0;
                wrap  = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
        hi_d = ((cnt_d & top) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pixdiv_core.sv
module pixdiv_core
    import pixdiv_pkg::*;
#(
    parameter int NSRC = 2,
    parameter int EMAX = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              cfg,
    input  logic [NDIV_W-1:0] ndiv_m1,
    input  logic [NSRC-1:0]   src_tick,
    output logic              src_ok,
    output logic              pix_clk,
    output logic              pix_stb
);

    localparam logic [SEL_W:0] NSRC_L = (SEL_W+1)'(NSRC);

    typedef struct packed {
        logic              run;
        logic [EXP_W-1:0]  a_exp;
        logic [NDIV_W-1:0] a_nm1;
        logic              pix;
        logic              stb;
    } core_t;

    core_t st_d, st_q;

    logic [NSRC-1:0] hit;
    logic tick, ok, clr, adv1;
    logic wrap1, wrap2, hi1, hi2;

    // Source tick selection, one comparator per source
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = src_tick[g] && (cfg.sel == SEL_W'(g));
    end

    assign src_ok = ({1'b0, cfg.sel} < NSRC_L);
    assign ok     = cfg.en && src_ok;
    assign tick   = |hit;
    assign clr    = !ok || (tick && !st_q.run);
    assign adv1   = ok && tick && st_q.run;

    pixdiv_ndiv #(.W(NDIV_W)) u_ndiv (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .adv  (adv1),
        .lim  (st_q.a_nm1),
        .wrap (wrap1),
        .hi_d (hi1)
    );

    pixdiv_pow2 #(.W(EMAX), .EW(EXP_W)) u_pow2 (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .adv  (wrap1),
        .exp  (st_q.a_exp),
        .wrap (wrap2),
        .hi_d (hi2)
    );

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (!ok) begin
            st_d.run   = 1'b0;
            st_d.pix   = 1'b0;
            st_d.a_exp = cfg.exp;
            st_d.a_nm1 = ndiv_m1;
        end else if (tick && !st_q.run) begin
            st_d.run   = 1'b1;
            st_d.pix   = 1'b1;
            st_d.stb   = 1'b1;
            st_d.a_exp = cfg.exp;
            st_d.a_nm1 = ndiv_m1;
        end else if (tick) begin
            if (wrap1 && wrap2) begin
                // Period boundary: the only point new settings are taken up
                st_d.pix   = 1'b1;
                st_d.stb   = 1'b1;
                st_d.a_exp = cfg.exp;
                st_d.a_nm1 = ndiv_m1;
            end else if (st_q.a_exp == '0) begin
                st_d.pix = hi1;
            end else begin
                st_d.pix = hi2;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_clk = st_q.pix;
    assign pix_stb = st_q.stb;

endmodule

// File: rtl/pixdiv_top.sv
module pixdiv_top
    import pixdiv_pkg::*;
#(
    parameter int NSRC  = 2,
    parameter int SHR_W = 32,
    parameter int NLSB  = 3,
    parameter int EMAX  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_tick,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              shr_we,
    input  logic [SHR_W-1:0]  shr_wdata,
    input  logic              nfld_we,
    input  logic [NDIV_W-1:0] nfld_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic [SHR_W-1:0]  shr_rdata,
    output logic              src_ok,
    output logic              pix_clk,
    output logic              pix_stb
);

    ctl_t              ctl_q;
    logic [NDIV_W-1:0] ndiv_m1;

    pixdiv_regs #(.SHR_W(SHR_W), .NLSB(NLSB), .EMAX(EMAX)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .shr_we    (shr_we),
        .shr_wdata (shr_wdata),
        .nfld_we   (nfld_we),
        .nfld_wdata(nfld_wdata),
        .ctl_q     (ctl_q),
        .shr_q     (shr_rdata),
        .ndiv_m1   (ndiv_m1)
    );

    pixdiv_core #(.NSRC(NSRC), .EMAX(EMAX)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (ctl_q),
        .ndiv_m1 (ndiv_m1),
        .src_tick(src_tick),
        .src_ok  (src_ok),
        .pix_clk (pix_clk),
        .pix_stb (pix_stb)
    );

    assign ctl_rdata = ctl_q;

endmodule

// File: rtl/pixdiv_chk.sv
module pixdiv_chk
    import pixdiv_pkg::*;
#(
    parameter int NSRC  = 2,
    parameter int SHR_W = 32,
    parameter int NLSB  = 3,
    parameter int EMAX  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NSRC-1:0]   src_tick,
    input logic              ctl_we,
    input logic              shr_we,
    input logic              nfld_we,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic [SHR_W-1:0]  shr_rdata,
    input logic              src_ok,
    input logic              pix_clk,
    input logic              pix_stb
);

    localparam logic [SHR_W-1:0] KEEP = ~({{(SHR_W-NDIV_W){1'b0}}, {NDIV_W{1'b1}}} << NLSB);

    logic sel_tick;
    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (ctl_rdata[SEL_W-1:0] == SEL_W'(i)) begin
                sel_tick = src_tick[i];
            end
        end
    end

    p_exp_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_W-1 -: EXP_W] <= EXP_W'(EMAX));

    p_ctl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_rdata));

    p_field_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nfld_we && !shr_we) |=> ((shr_rdata & KEEP) == ($past(shr_rdata) & KEEP)));

    p_strobe_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_tick == 1'b0 |=> !pix_stb);

    p_strobe_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |-> pix_clk);

    p_off_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[SEL_W] |=> (!pix_clk && !pix_stb));

    p_bad_src_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !src_ok |=> (!pix_clk && !pix_stb));

    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[SEL_W] && src_ok && !sel_tick) |=> $stable(pix_clk));

endmodule

bind pixdiv_top pixdiv_chk #(
    .NSRC (NSRC),
    .SHR_W(SHR_W),
    .NLSB (NLSB),
    .EMAX (EMAX)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .ctl_we   (ctl_we),
    .shr_we   (shr_we),
    .nfld_we  (nfld_we),
    .ctl_rdata(ctl_rdata),
    .shr_rdata(shr_rdata),
    .src_ok   (src_ok),
    .pix_clk  (pix_clk),
    .pix_stb  (pix_stb)
);

// File: tb/pixdiv_top_test.sv
module pixdiv_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 2;
    localparam int SHR_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_tick = '0;
    logic             ctl_we = 1'b0;
    logic [5:0]       ctl_wdata = '0;
    logic             shr_we = 1'b0;
    logic [SHR_W-1:0] shr_wdata = '0;
    logic             nfld_we = 1'b0;
    logic [4:0]       nfld_wdata = '0;
    logic [5:0]       ctl_rdata;
    logic [SHR_W-1:0] shr_rdata;
    logic             src_ok, pix_clk, pix_stb;

    pixdiv_top uut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .shr_we(shr_we), .shr_wdata(shr_wdata),
        .nfld_we(nfld_we), .nfld_wdata(nfld_wdata),
        .ctl_rdata(ctl_rdata), .shr_rdata(shr_rdata),
        .src_ok(src_ok), .pix_clk(pix_clk), .pix_stb(pix_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // Reference model state
    int         m_run = 0, m_pos = 0, m_n = 1, m_e = 0;
    logic       m_pix = 1'b0, m_stb = 1'b0;
    logic [5:0] m_ctl = '0;
    logic [31:0] m_shr = '0;

    function automatic logic [5:0] cap_exp(logic [5:0] w);
        if (w[5:3] > 3'd5) w[5:3] = 3'd5;
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        int  cur_n, cur_e, d;
        bit  ok, tk;
        cur_n = int'(m_shr[7:3]) + 1;
        cur_e = int'(m_ctl[5:3]);
        ok    = m_ctl[2] && (m_ctl[1:0] < 2'd2);
        tk    = ok && src_tick[m_ctl[0]];
        if (!ok) begin
            m_run = 0; m_pos = 0; m_pix = 1'b0; m_stb = 1'b0;
        end else if (tk && m_run == 0) begin
            m_run = 1; m_pos = 0; m_n = cur_n; m_e = cur_e;
            m_pix = 1'b1; m_stb = 1'b1;
        end else if (tk) begin
            m_pos++;
            m_stb = 1'b0;
            if (m_pos == (m_n << m_e)) begin
                m_pos = 0; m_n = cur_n; m_e = cur_e; m_stb = 1'b1;
            end
            d = m_n << m_e;
            m_pix = (m_pos < (d + 1) / 2);
        end else begin
            m_stb = 1'b0;
        end
        if (ctl_we) m_ctl = cap_exp(ctl_wdata);
        if (shr_we) m_shr = shr_wdata;
        if (nfld_we) m_shr[7:3] = nfld_wdata;
        @(posedge clk);
        #1;
        chk("R5 pix_clk", 32'(pix_clk), 32'(m_pix));
        chk("R4 pix_stb", 32'(pix_stb), 32'(m_stb));
        chk("R1 ctl_rdata", 32'(ctl_rdata), 32'(m_ctl));
        chk("R3 shr_rdata", shr_rdata, m_shr);
        chk("R7 src_ok", 32'(src_ok), 32'(m_ctl[1:0] < 2'd2));
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        ctl_we = 1'b1; ctl_wdata = v; step(); ctl_we = 1'b0;
    endtask

    task automatic wr_nfld(input logic [4:0] v);
        nfld_we = 1'b1; nfld_wdata = v; step(); nfld_we = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        int k;
        logic prev;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk("R1 reset ctl", 32'(ctl_rdata), 32'h0);
        chk("R1 reset shr", shr_rdata, 32'h0);
        chk("R6 reset pix", 32'(pix_clk), 32'h0);

        // R2: exponent cap
        wr_ctl({3'd7, 1'b0, 2'd1});
        chk("R2 exp capped", 32'(ctl_rdata[5:3]), 32'd5);

        // R3: full write then field-only write
        shr_we = 1'b1; shr_wdata = 32'hDEADBEEF; step(); shr_we = 1'b0;
        wr_nfld(5'h0A);
        chk("R3 field write", shr_rdata, (32'hDEADBEEF & ~32'hF8) | 32'h50);
        // R3: both strobes in one cycle
        shr_we = 1'b1; shr_wdata = 32'h12345678; nfld_we = 1'b1; nfld_wdata = 5'h1F;
        step(); shr_we = 1'b0; nfld_we = 1'b0;
        chk("R3 both writes", shr_rdata, 32'h123456F8);

        // R5: N=3, E=0 on source 0, tick every cycle: high 2, low 1
        wr_nfld(5'd2);
        wr_ctl({3'd0, 1'b1, 2'd0});
        src_tick = 2'b01;
        k = 0;
        for (int i = 0; i < 9; i++) begin
            step();
            if (pix_clk) k++;
        end
        chk("R5 odd N high count", 32'(k), 32'd6);

        // R9: only the other source ticks: output frozen
        src_tick = 2'b10;
        prev = pix_clk;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R9 foreign tick ignored", 32'(pix_clk), 32'(prev));
        end

        // R6: disable, then re-enable
        src_tick = 2'b01;
        wr_ctl({3'd0, 1'b0, 2'd0});
        step();
        chk("R6 disabled low", 32'(pix_clk), 32'h0);
        src_tick = 2'b00;
        wr_ctl({3'd0, 1'b1, 2'd0});
        step();
        chk("R6 enabled no tick yet", 32'(pix_clk), 32'h0);
        src_tick = 2'b01;
        step();
        chk("R6 first tick high", 32'(pix_clk), 32'h1);
        chk("R6 first tick strobe", 32'(pix_stb), 32'h1);

        // R7: invalid source code 2
        wr_ctl({3'd0, 1'b1, 2'd2});
        src_tick = 2'b11;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R7 invalid source idle", 32'(pix_clk | pix_stb), 32'h0);
        end
        chk("R7 src_ok low", 32'(src_ok), 32'h0);

        // R10: N=1, E=0 on source 1
        wr_nfld(5'd0);
        wr_ctl({3'd0, 1'b1, 2'd1});
        src_tick = 2'b10;
        k = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (pix_clk && pix_stb) k++;
        end
        chk("R10 divide by one", 32'(k), 32'd6);

        // R8: N=2, E=1 (4 ticks); change N mid-period
        src_tick = 2'b00;
        wr_ctl({3'd1, 1'b0, 2'd0});
        wr_nfld(5'd1);
        wr_ctl({3'd1, 1'b1, 2'd0});
        src_tick = 2'b01;
        step();
        chk("R8 period start", 32'(pix_stb), 32'h1);
        wr_nfld(5'd0);
        k = 0;
        for (int i = 0; i < 10; i++) begin
            step(); k++;
            if (pix_stb) break;
        end
        chk("R8 old period kept", 32'(k), 32'd3);
        k = 0;
        for (int i = 0; i < 10; i++) begin
            step(); k++;
            if (pix_stb) break;
        end
        chk("R8 new period used", 32'(k), 32'd2);

        // R4: random stimulus against the model
        for (int i = 0; i < 20000; i++) begin
            int r;
            src_tick = NSRC'($urandom);
            r = int'($urandom % 100);
            if (r < 3) begin
                int s, e;
                s = ($urandom % 8 == 0) ? int'(2 + $urandom % 2) : int'($urandom % 2);
                e = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 3);
                ctl_we = 1'b1;
                ctl_wdata = {3'(e), ($urandom % 10 != 0), 2'(s)};
            end else if (r < 5) begin
                nfld_we = 1'b1;
                nfld_wdata = ($urandom % 3 == 0) ? 5'($urandom) : 5'($urandom % 6);
            end else if (r < 6) begin
                shr_we = 1'b1;
                shr_wdata = $urandom;
            end
            step();
            ctl_we = 1'b0; nfld_we = 1'b0; shr_we = 1'b0;
        end

        summary();
        $finish;
    end

endmodule